// File: doc/BRIEF.md
# SPI Target Transaction Engine

This block is the target (slave) side of an SPI link. It samples SCK, MOSI and an active-low chip select in its own system clock domain and drives MISO. The data it shifts out comes from a small transmit buffer, and the data it shifts in goes to a small receive buffer. A host loads the transmit buffer through a valid/ready write port and reads the receive buffer through a plain combinational read port.

Each transaction runs from the falling edge of chip select to its rising edge. The engine enforces separate transmit and receive length limits for every transaction. Once the transmit limit is used up, every further byte goes out as a configured over-read character. Bytes that arrive past the receive limit are dropped. In both cases a sticky flag is raised. An ownership grant input decides whether a transaction touches the buffers at all. Without a grant, the engine only clocks out a fixed fill character.

The transmit write port applies back-pressure. `txw_ready` is low for the whole time a transaction is active, and a write is taken only in a cycle where `txw_valid` and `txw_ready` are both high. The receive read port has no handshake. Its data is only meaningful while no transaction is active.

Top module: `spi_target_engine`

## Requirements
- R1: After reset the block is idle: `xfer_end`, `tx_count`, `rx_count`, both flags and `spi_miso` are 0, and `txw_ready` is 1.
- R2: All four clock modes work. `cfg_cpol` sets the idle clock level (0 = low, 1 = high). With `cfg_cpha`=0 the block samples MOSI on the leading edge and changes MISO on the trailing edge, and the first bit is on MISO before the first edge. With `cfg_cpha`=1 it changes MISO on the leading edge and samples on the trailing edge.
- R3: `cfg_lsb_first`=1 shifts bit 0 of each byte first in both directions. With 0, bit 7 goes first.
- R4: In a granted transaction, byte n on MISO is transmit buffer entry n while n is below the effective transmit limit. Every later byte is `cfg_overread_char`. Completing such a later byte sets `flag_overread`.
- R5: In a granted transaction, completed byte n is written to receive buffer entry n while n is below the effective receive limit. Later bytes are discarded and set `flag_overflow`.
- R6: A granted transaction clears both counts at its start. Each completed byte then adds one to `tx_count` and to `rx_count`, but each count stops at its effective limit. The effective limit is the configured 8-bit limit capped at DEPTH.
- R7: A transaction that starts while `own_grant` is low sends `cfg_fill_char` for every byte. It stores nothing and leaves both counts and both flags unchanged.
- R8: The rising edge of chip select ends a transaction and produces `xfer_end` high for exactly one cycle. A partly received byte at that point is dropped and not counted.
- R9: Both flags stay set until a one is written to `clr_overflow` or `clr_overread`, and they are not cleared any other way.
- R10: `txw_ready` is 0 while a transaction is active and 1 when idle, including the cycle in which `xfer_end` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least 4x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_csn | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the master |
| own_grant | input | 1 | Buffer ownership; sampled when chip select falls |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_tx_limit | input | 8 | Transmit byte limit |
| cfg_rx_limit | input | 8 | Receive byte limit |
| cfg_fill_char | input | 8 | Character sent when no grant is held |
| cfg_overread_char | input | 8 | Character sent past the transmit limit |
| txw_valid | input | 1 | Transmit buffer write request |
| txw_ready | output | 1 | Write accepted (idle only) |
| txw_addr | input | AW | Transmit buffer write index |
| txw_data | input | 8 | Transmit buffer write byte |
| rxr_addr | input | AW | Receive buffer read index |
| rxr_data | output | 8 | Receive buffer byte at rxr_addr |
| xfer_end | output | 1 | One-cycle pulse at the end of a transaction |
| tx_count | output | 8 | Bytes sent from the buffer in the last granted transaction |
| rx_count | output | 8 | Bytes stored in the last granted transaction |
| flag_overflow | output | 1 | Sticky receive overflow |
| flag_overread | output | 1 | Sticky transmit over-read |
| clr_overflow | input | 1 | Write one to clear flag_overflow |
| clr_overread | input | 1 | Write one to clear flag_overread |

## Verification
The bench runs all eight combinations of polarity, phase and bit order. In each one, the transmit and receive limits are set below, at and above the number of bytes sent. If an edge selection or bit order were wrong, the bytes the master reads would be shifted, mirrored or one bit off. If a limit comparison were off by one, the first over-read byte, the last stored byte or a count would be wrong. Further tests hit a byte limit above the buffer depth, a transaction cut off part way through a byte, and an ungranted transaction that follows one which set both flags. These would catch an engine that fails to cap at DEPTH, counts a partial byte, or lets an ungranted master disturb the counts, the flags or the stored data.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // Increment that holds at all-ones.
  function automatic byte_t sat_inc(input byte_t v);
    return (v == '1) ? v : v + byte_t'(1);
  endfunction

  // Insert one received bit according to bit order.
  function automatic byte_t shift_in(input byte_t sr, input logic b, input logic lsb_first);
    return lsb_first ? {b, sr[BYTE_W-1:1]} : {sr[BYTE_W-2:0], b};
  endfunction

  // Limit capped at buffer depth.
  function automatic byte_t cap_limit(input byte_t lim, input byte_t depth);
    return (lim > depth) ? depth : lim;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int         W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_tgt_bytemem.sv
module spi_tgt_bytemem #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_target_engine.sv
module spi_target_engine
  import spi_tgt_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_csn,
  output logic          spi_miso,
  input  logic          own_grant,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_lsb_first,
  input  logic [7:0]    cfg_tx_limit,
  input  logic [7:0]    cfg_rx_limit,
  input  logic [7:0]    cfg_fill_char,
  input  logic [7:0]    cfg_overread_char,
  input  logic          txw_valid,
  output logic          txw_ready,
  input  logic [AW-1:0] txw_addr,
  input  logic [7:0]    txw_data,
  input  logic [AW-1:0] rxr_addr,
  output logic [7:0]    rxr_data,
  output logic          xfer_end,
  output logic [7:0]    tx_count,
  output logic [7:0]    rx_count,
  output logic          flag_overflow,
  output logic          flag_overread,
  input  logic          clr_overflow,
  input  logic          clr_overread
);
  localparam byte_t DEPTH_B = byte_t'(DEPTH);

  // Synchronised pins: {csn, sck, mosi}
  logic [2:0] syn_q;
  logic csn_s, sck_s, mosi_s, csn_p, sck_p;

  spi_tgt_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_csn, spi_sck, spi_mosi}), .q(syn_q)
  );
  assign {csn_s, sck_s, mosi_s} = syn_q;

  // Engine state
  logic       active, grant_q, first_q;
  logic [2:0] out_cnt, in_cnt;
  byte_t      rx_sr, cur_byte, ld_idx, byte_idx;

  // Edge classification
  logic cs_fall, cs_rise, sck_rise, sck_fall, lead_e, trail_e, samp_e, shft_e;
  assign cs_fall  = csn_p & ~csn_s;
  assign cs_rise  = ~csn_p & csn_s;
  assign sck_rise = sck_s & ~sck_p;
  assign sck_fall = ~sck_s & sck_p;
  assign lead_e   = cfg_cpol ? sck_fall : sck_rise;
  assign trail_e  = cfg_cpol ? sck_rise : sck_fall;
  assign samp_e   = active & ~csn_s & (cfg_cpha ? trail_e : lead_e);
  assign shft_e   = active & ~csn_s & (cfg_cpha ? lead_e : trail_e);

  // Limits and next byte to present
  byte_t tx_lim, rx_lim, rd_idx, tx_rdata, nxt_byte, rx_byte;
  logic  grant_eff, wrap, done, rx_ok, tx_ok, rx_we;

  assign tx_lim    = cap_limit(cfg_tx_limit, DEPTH_B);
  assign rx_lim    = cap_limit(cfg_rx_limit, DEPTH_B);
  assign grant_eff = cs_fall ? own_grant : grant_q;
  assign rd_idx    = cs_fall ? '0 : sat_inc(ld_idx);
  assign nxt_byte  = !grant_eff       ? cfg_fill_char :
                     (rd_idx < tx_lim) ? tx_rdata : cfg_overread_char;
  assign wrap      = shft_e & ~(cfg_cpha & first_q) & (out_cnt == 3'd7);

  assign rx_byte = shift_in(rx_sr, mosi_s, cfg_lsb_first);
  assign done    = samp_e & (in_cnt == 3'd7) & grant_q;
  assign rx_ok   = byte_idx < rx_lim;
  assign tx_ok   = byte_idx < tx_lim;
  assign rx_we   = done & rx_ok;

  assign txw_ready = ~active;

  spi_tgt_bytemem #(.DEPTH(DEPTH), .AW(AW)) u_txmem (
    .clk(clk), .we(txw_valid & txw_ready), .waddr(txw_addr), .wdata(txw_data),
    .raddr(rd_idx[AW-1:0]), .rdata(tx_rdata)
  );

  spi_tgt_bytemem #(.DEPTH(DEPTH), .AW(AW)) u_rxmem (
    .clk(clk), .we(rx_we), .waddr(byte_idx[AW-1:0]), .wdata(rx_byte),
    .raddr(rxr_addr), .rdata(rxr_data)
  );

  // Transaction sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_p    <= 1'b1;
      sck_p    <= 1'b0;
      active   <= 1'b0;
      grant_q  <= 1'b0;
      first_q  <= 1'b0;
      out_cnt  <= '0;
      in_cnt   <= '0;
      rx_sr    <= '0;
      cur_byte <= '0;
      ld_idx   <= '0;
      byte_idx <= '0;
      tx_count <= '0;
      rx_count <= '0;
      xfer_end <= 1'b0;
    end else begin
      csn_p    <= csn_s;
      sck_p    <= sck_s;
      xfer_end <= 1'b0;
      if (cs_fall) begin
        active   <= 1'b1;
        grant_q  <= own_grant;
        first_q  <= 1'b1;
        out_cnt  <= '0;
        in_cnt   <= '0;
        ld_idx   <= '0;
        byte_idx <= '0;
        cur_byte <= nxt_byte;
        if (own_grant) begin
          tx_count <= '0;
          rx_count <= '0;
        end
      end else if (cs_rise && active) begin
        active   <= 1'b0;
        xfer_end <= 1'b1;
      end else if (active) begin
        if (shft_e) begin
          if (cfg_cpha && first_q) begin
            first_q <= 1'b0;
          end else begin
            out_cnt <= out_cnt + 3'd1;
            if (wrap) begin
              ld_idx   <= rd_idx;
              cur_byte <= nxt_byte;
            end
          end
        end
        if (samp_e) begin
          rx_sr  <= rx_byte;
          in_cnt <= in_cnt + 3'd1;
        end
        if (done) begin
          byte_idx <= sat_inc(byte_idx);
          if (rx_ok) rx_count <= rx_count + 8'd1;
          if (tx_ok) tx_count <= tx_count + 8'd1;
        end
      end
    end
  end

  // Sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_overflow <= 1'b0;
      flag_overread <= 1'b0;
    end else begin
      flag_overflow <= (flag_overflow & ~clr_overflow) | (done & ~rx_ok);
      flag_overread <= (flag_overread & ~clr_overread) | (done & ~tx_ok);
    end
  end

  assign spi_miso = (active & ~csn_s) ?
                    cur_byte[cfg_lsb_first ? out_cnt : ~out_cnt] : 1'b0;

endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_end,
  input logic       txw_ready,
  input logic [7:0] tx_count,
  input logic [7:0] rx_count,
  input logic       flag_overflow,
  input logic       flag_overread,
  input logic       clr_overflow,
  input logic       clr_overread
);
  localparam logic [7:0] DEPTH_B = 8'(DEPTH);

  a_r8_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);

  a_r10_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> txw_ready);

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_overflow && !clr_overflow) |=> flag_overflow);

  a_r9_overread_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_overread && !clr_overread) |=> flag_overread);

  a_r6_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != $past(rx_count)) |-> (rx_count == $past(rx_count) + 8'd1 || rx_count == 8'd0));

  a_r6_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count != $past(tx_count)) |-> (tx_count == $past(tx_count) + 8'd1 || tx_count == 8'd0));

  a_r6_rx_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= DEPTH_B);

  a_r6_tx_cap: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= DEPTH_B);
endmodule

bind spi_target_engine spi_tgt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end), .txw_ready(txw_ready),
  .tx_count(tx_count), .rx_count(rx_count),
  .flag_overflow(flag_overflow), .flag_overread(flag_overread),
  .clr_overflow(clr_overflow), .clr_overread(clr_overread)
);

// File: tb/spi_target_engine_tb_top.sv
`timescale 1ns/1ps
module spi_target_engine_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 3;
  localparam int HP    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1, miso;
  logic grant = 1'b1, cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
  logic [7:0] tlim = 8'd0, rlim = 8'd0, fillc = 8'h5A, orc = 8'hE0;
  logic txw_valid = 1'b0, txw_ready;
  logic [AW-1:0] txw_addr = '0, rxr_addr = '0;
  logic [7:0] txw_data = '0, rxr_data;
  logic xfer_end;
  logic [7:0] tx_count, rx_count;
  logic f_ovf, f_ovr;
  logic clr_ovf = 1'b0, clr_ovr = 1'b0;

  always #2 clk = ~clk;

  spi_target_engine #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_csn(csn),
    .spi_miso(miso), .own_grant(grant), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsb), .cfg_tx_limit(tlim), .cfg_rx_limit(rlim),
    .cfg_fill_char(fillc), .cfg_overread_char(orc),
    .txw_valid(txw_valid), .txw_ready(txw_ready), .txw_addr(txw_addr),
    .txw_data(txw_data), .rxr_addr(rxr_addr), .rxr_data(rxr_data),
    .xfer_end(xfer_end), .tx_count(tx_count), .rx_count(rx_count),
    .flag_overflow(f_ovf), .flag_overread(f_ovr),
    .clr_overflow(clr_ovf), .clr_overread(clr_ovr)
  );

  int nchk = 0, nfail = 0, cyc = 0, end_hi = 0;
  logic done_all = 1'b0;
  logic ready_mid;
  logic [7:0] mosi_b [16];
  logic [7:0] miso_b [16];
  logic [7:0] txm    [DEPTH];

  always @(negedge clk) if (rst_n && xfer_end) end_hi++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done_all) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tx(input int a, input logic [7:0] d);
    @(negedge clk);
    txw_valid = 1'b1; txw_addr = AW'(a); txw_data = d;
    @(negedge clk);
    txw_valid = 1'b0;
  endtask

  task automatic rd_rx(input int a, output logic [7:0] d);
    @(negedge clk);
    rxr_addr = AW'(a);
    @(negedge clk);
    d = rxr_data;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_ovf = 1'b1; clr_ovr = 1'b1;
    @(negedge clk);
    clr_ovf = 1'b0; clr_ovr = 1'b0;
    wclk(1);
  endtask

  // Master: nb whole bytes then xb extra bits
  task automatic run_txn(input int nb, input int xb);
    @(negedge clk);
    sck = cpol;
    csn = 1'b0;
    wclk(HP);
    ready_mid = txw_ready;
    for (int i = 0; i < nb * 8 + xb; i++) begin
      int bi, pos;
      bi  = i / 8;
      pos = lsb ? (i % 8) : 7 - (i % 8);
      if (!cpha) begin
        mosi = mosi_b[bi][pos];
        wclk(HP);
        miso_b[bi][pos] = miso;
        sck = ~cpol;
        wclk(HP);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mosi_b[bi][pos];
        wclk(HP);
        miso_b[bi][pos] = miso;
        sck = cpol;
        wclk(HP);
      end
    end
    wclk(HP);
    csn = 1'b1;
    wclk(10);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    logic [7:0] rb;
    int te, re, e0, nb;
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    // R1 reset state
    chk("R1 xfer_end", xfer_end, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 flags", {f_ovf, f_ovr}, 0);
    chk("R1 txw_ready", txw_ready, 1);
    chk("R1 miso idle", miso, 0);

    // R2/R3 sweep of all modes and bit orders with varied limits
    for (int k = 0; k < 8; k++) begin
      cpol = k[2]; cpha = k[1]; lsb = k[0];
      tlim = 8'((k * 3) % 7);
      rlim = 8'((k * 5 + 2) % 7);
      orc  = 8'hE0 | 8'(k);
      nb   = 5;
      for (int i = 0; i < DEPTH; i++) begin
        txm[i] = (8'h11 * 8'(i + 1)) ^ 8'(k * 7);
        wr_tx(i, txm[i]);
      end
      for (int i = 0; i < 16; i++) mosi_b[i] = 8'((37 * i + 13 * k + 5) & 255);
      e0 = end_hi;
      run_txn(nb, 0);
      te = imin(int'(tlim), DEPTH);
      re = imin(int'(rlim), DEPTH);
      for (int i = 0; i < nb; i++)
        chk($sformatf("R2 R3 R4 miso k=%0d byte=%0d", k, i), miso_b[i],
            (i < te) ? txm[i] : orc);
      for (int i = 0; i < imin(nb, re); i++) begin
        rd_rx(i, rb);
        chk($sformatf("R2 R3 R5 stored k=%0d byte=%0d", k, i), rb, mosi_b[i]);
      end
      chk($sformatf("R6 tx_count k=%0d", k), tx_count, imin(nb, te));
      chk($sformatf("R6 rx_count k=%0d", k), rx_count, imin(nb, re));
      chk($sformatf("R4 overread k=%0d", k), f_ovr, (nb > te) ? 1 : 0);
      chk($sformatf("R5 overflow k=%0d", k), f_ovf, (nb > re) ? 1 : 0);
      chk($sformatf("R8 end pulse k=%0d", k), end_hi - e0, 1);
      chk($sformatf("R10 busy ready k=%0d", k), ready_mid, 0);
      chk($sformatf("R10 idle ready k=%0d", k), txw_ready, 1);
      clear_flags();
      chk($sformatf("R9 cleared k=%0d", k), {f_ovf, f_ovr}, 0);
    end

    // R9 stickiness, then R7 ungranted transaction leaves everything
    cpol = 0; cpha = 0; lsb = 0; tlim = 8'd1; rlim = 8'd1; orc = 8'hC3;
    for (int i = 0; i < 16; i++) mosi_b[i] = 8'(8'h70 + i);
    run_txn(2, 0);
    wclk(20);
    chk("R9 flags held", {f_ovf, f_ovr}, 3);
    grant = 1'b0;
    for (int i = 0; i < 16; i++) mosi_b[i] = 8'(8'h90 + i);
    run_txn(3, 0);
    for (int i = 0; i < 3; i++)
      chk($sformatf("R7 fill byte=%0d", i), miso_b[i], fillc);
    chk("R7 tx_count kept", tx_count, 1);
    chk("R7 rx_count kept", rx_count, 1);
    chk("R7 flags kept", {f_ovf, f_ovr}, 3);
    rd_rx(0, rb);
    chk("R7 buffer kept", rb, 8'h70);
    grant = 1'b1;
    clear_flags();

    // R8 partial byte dropped
    tlim = 8'd8; rlim = 8'd8;
    for (int i = 0; i < 16; i++) mosi_b[i] = 8'(8'h21 * i + 3);
    e0 = end_hi;
    run_txn(2, 3);
    chk("R8 partial tx_count", tx_count, 2);
    chk("R8 partial rx_count", rx_count, 2);
    chk("R8 partial flags", {f_ovf, f_ovr}, 0);
    chk("R8 partial end pulse", end_hi - e0, 1);

    // R6 limit above depth is capped
    tlim = 8'd255; rlim = 8'd200; orc = 8'hA5;
    run_txn(10, 0);
    chk("R6 cap tx_count", tx_count, DEPTH);
    chk("R6 cap rx_count", rx_count, DEPTH);
    chk("R4 cap overread", f_ovr, 1);
    chk("R5 cap overflow", f_ovf, 1);
    chk("R4 cap last buffered", miso_b[7], txm[7]);
    chk("R4 cap orc 8", miso_b[8], orc);
    chk("R4 cap orc 9", miso_b[9], orc);
    rd_rx(7, rb);
    chk("R5 cap last stored", rb, mosi_b[7]);

    done_all = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule